// File: doc/BRIEF.md
# Multi-Lane Random Word Generator

This block holds separate random-generator state for up to `LANES` lanes and serves four commands through one command port: configure, seed a lane, read a lane's state back, and generate one 32-bit value for every active lane. Two recurrences are built in. The first is a single-word 32-bit xorshift generator. The second is a six-word xorwow generator, with words x, y, z, w and v plus a Weyl counter d.

Every command is checked before it takes effect. An illegal combination raises a one-cycle error pulse and changes neither lane state nor configuration. A generate command walks lanes 0 to count-1 in order, one lane after another. For each lane it advances the state the configured number of steps. It then emits either the raw word or a unit-interval float bit pattern on a valid/ready output stream.

Back-pressure rules:
- The command port is accepted only while `cmd_ready` is high, and `cmd_ready` is low for the whole of a generate run.
- On the output stream, a word is presented with `out_valid` and held unchanged until `out_ready` is sampled high.
- A lane's advanced state is written back only on that handshake.

Top module: `rng_lanes`

## Requirements
- R1: Algorithm code 1 or 2 on a configure, set-state or get-state command pulses `err_algo` for one cycle after acceptance. Neither configuration nor lane state changes, and `rd_valid` stays low. The algorithm codes are 0 = xorshift and 3 = xorwow.
- R2: The state-source code must match the algorithm on configure, set-state and get-state. Source 0 or 3 goes only with algorithm 0, and source 1 only with algorithm 3. Any other pair pulses `err_param` with no effect.
- R3: On configure, the step count must be at least 1 for algorithm 0 and exactly 1 for algorithm 3. Otherwise `err_param` pulses and the previous configuration stays in force.
- R4: On configure, post-process code 2 or 3 is rejected with `err_param`. A lane count outside 1..`LANES` is also rejected with `err_param`.
- R5: Set-state with algorithm 0 writes only state word 0 of the lane. It takes seed word 0, or the value 1 if seed word 0 is zero, and it is rejected with `err_param` if seed words 1..5 are not all zero. Set-state with algorithm 3 writes all six words from seed words 0..5 (x, y, z, w, v, d).
- R6: Get-state pulses `rd_valid` one cycle after acceptance, with state word k on `rd_words` bits [32k+31:32k]. For algorithm 0 only word 0 is returned, and the upper words read as zero.
- R7: Under algorithm 0, each step applies x ^= x<<13; x ^= x>>17; x ^= x<<5. The emitted raw value is the state after all steps.
- R8: Under algorithm 3, each step computes t = x ^ (x>>2), shifts the words down (x<=y, y<=z, z<=w, w<=v), sets v <= (v ^ (v<<4)) ^ (t ^ (t<<1)) and adds 362437 to d. The raw value is v + d.
- R9: Post-process code 0 emits the raw word. Code 1 emits 0x3F800000 OR'd with the upper 23 bits of the raw word placed in bits 22:0.
- R10: Generate emits lanes 0..count-1 in order, with the index on `out_lane` and `out_last` set on the final lane. Lanes at or above the count keep their state. A generate before any accepted configure pulses `err_param` and emits nothing.
- R11: While `out_valid` is high and `out_ready` is low, data, lane and last are held. `cmd_ready` is low while output is pending.
- R12: After reset all lane state words are zero, no configuration is valid, `cmd_ready` is high, and all outputs and pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 2 | 0 configure, 1 set-state, 2 get-state, 3 generate |
| cmd_lane | input | LW | Lane addressed by set-state / get-state |
| cmd_algo | input | 2 | Algorithm code |
| cmd_src | input | 2 | State-source code, checked against the algorithm |
| cmd_steps | input | STEPW | Advances per output (configure) |
| cmd_post | input | 2 | Post-process code (configure) |
| cmd_count | input | LW+1 | Active lane count (configure) |
| cmd_seed | input | 192 | Six seed words, word k at bits [32k+31:32k] |
| err_algo | output | 1 | Unsupported algorithm pulse |
| err_param | output | 1 | Illegal field combination pulse |
| rd_valid | output | 1 | Get-state result valid pulse |
| rd_words | output | 192 | Get-state result |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 32 | Raw or float-pattern random word |
| out_lane | output | LW | Lane of the current output word |
| out_last | output | 1 | Current word is the last active lane |

## Verification
The bench builds the block with `LANES` = 16 and `STEPW` = 8. At that size a full sweep over every lane is short enough to repeat, and both lane-count edges are within reach: 16 is accepted and 17 is rejected. With eight step bits, the one-step minimum and multi-step xorshift runs are exercised alongside xorwow runs. Random output stalls keep the held-data rule and the lane-order rule under pressure.

// File: rtl/rng_lanes_pkg.sv
package rng_lanes_pkg;
  localparam int unsigned NWORD = 6;
  localparam logic [31:0] WEYL_INC = 32'd362437;
  localparam logic [31:0] UNIT_EXP = 32'h3F80_0000;

  typedef logic [NWORD-1:0][31:0] state_t;

  typedef enum logic [1:0] {
    OP_CFG = 2'd0,
    OP_SET = 2'd1,
    OP_GET = 2'd2,
    OP_GEN = 2'd3
  } op_e;

  localparam logic [1:0] ALG_XS = 2'd0;
  localparam logic [1:0] ALG_XW = 2'd3;
  localparam logic [1:0] PP_RAW = 2'd0;
  localparam logic [1:0] PP_UNIT = 2'd1;
endpackage

// File: rtl/rng_xs_step.sv
module rng_xs_step (
  input  logic [31:0] cur,
  output logic [31:0] nxt
);
  logic [31:0] a, b;
  always_comb begin
    a   = cur ^ (cur << 13);
    b   = a ^ (a >> 17);
    nxt = b ^ (b << 5);
  end
endmodule

// File: rtl/rng_xw_step.sv
module rng_xw_step
  import rng_lanes_pkg::*;
(
  input  state_t cur,
  output state_t nxt
);
  logic [31:0] t;
  always_comb begin
    t      = cur[0] ^ (cur[0] >> 2);
    nxt[0] = cur[1];
    nxt[1] = cur[2];
    nxt[2] = cur[3];
    nxt[3] = cur[4];
    nxt[4] = (cur[4] ^ (cur[4] << 4)) ^ (t ^ (t << 1));
    nxt[5] = cur[5] + WEYL_INC;
  end
endmodule

// File: rtl/rng_cmd_check.sv
module rng_cmd_check
  import rng_lanes_pkg::*;
#(
  parameter int LANES = 128,
  parameter int STEPW = 8,
  localparam int CW = $clog2(LANES) + 1
) (
  input  logic [1:0]       op,
  input  logic [1:0]       algo,
  input  logic [1:0]       src,
  input  logic [STEPW-1:0] steps,
  input  logic [1:0]       post,
  input  logic [CW-1:0]    count,
  input  state_t           seed,
  input  logic             cfg_ok,
  output logic             bad_algo,
  output logic             bad_param
);
  logic pair_ok, steps_ok, post_ok, cnt_ok, seed_ok, alg_ok;

  always_comb begin
    alg_ok   = (algo == ALG_XS) || (algo == ALG_XW);
    pair_ok  = ((algo == ALG_XS) && ((src == 2'd0) || (src == 2'd3))) ||
               ((algo == ALG_XW) && (src == 2'd1));
    steps_ok = (algo == ALG_XS) ? (steps != '0) : (steps == STEPW'(1));
    post_ok  = (post == PP_RAW) || (post == PP_UNIT);
    cnt_ok   = (count != '0) && (count <= CW'(LANES));
    seed_ok  = (algo != ALG_XS) || (seed[NWORD-1:1] == '0);

    bad_algo  = 1'b0;
    bad_param = 1'b0;
    case (op)
      OP_CFG: begin
        bad_algo  = !alg_ok;
        bad_param = alg_ok && !(pair_ok && steps_ok && post_ok && cnt_ok);
      end
      OP_SET: begin
        bad_algo  = !alg_ok;
        bad_param = alg_ok && !(pair_ok && seed_ok);
      end
      OP_GET: begin
        bad_algo  = !alg_ok;
        bad_param = alg_ok && !pair_ok;
      end
      default: bad_param = !cfg_ok;
    endcase
  end
endmodule

// File: rtl/rng_lanes.sv
module rng_lanes
  import rng_lanes_pkg::*;
#(
  parameter int LANES = 128,
  parameter int STEPW = 8,
  localparam int LW  = $clog2(LANES),
  localparam int CW  = LW + 1,
  localparam int SWB = NWORD * 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [LW-1:0]    cmd_lane,
  input  logic [1:0]       cmd_algo,
  input  logic [1:0]       cmd_src,
  input  logic [STEPW-1:0] cmd_steps,
  input  logic [1:0]       cmd_post,
  input  logic [CW-1:0]    cmd_count,
  input  logic [SWB-1:0]   cmd_seed,
  output logic             err_algo,
  output logic             err_param,
  output logic             rd_valid,
  output logic [SWB-1:0]   rd_words,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic [LW-1:0]    out_lane,
  output logic             out_last
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_ADV, S_EMIT} st_e;

  st_e              st;
  state_t           mem [LANES];
  state_t           wrk, xw_nxt, adv_nxt, seed_s;
  logic [31:0]      xs_nxt, raw;
  logic [STEPW-1:0] cnt;
  logic [LW-1:0]    lane;
  logic             cfg_ok;
  logic [1:0]       cfg_alg, cfg_post;
  logic [STEPW-1:0] cfg_steps;
  logic [CW-1:0]    cfg_cnt;
  logic             bad_algo, bad_param, acc, cmd_good, set_ok, wb;

  assign seed_s = state_t'(cmd_seed);

  rng_cmd_check #(.LANES(LANES), .STEPW(STEPW)) u_chk_cmd (
    .op(cmd_op), .algo(cmd_algo), .src(cmd_src), .steps(cmd_steps),
    .post(cmd_post), .count(cmd_count), .seed(seed_s), .cfg_ok(cfg_ok),
    .bad_algo(bad_algo), .bad_param(bad_param)
  );

  rng_xs_step u_xs (.cur(wrk[0]), .nxt(xs_nxt));
  rng_xw_step u_xw (.cur(wrk), .nxt(xw_nxt));

  always_comb begin
    adv_nxt = xw_nxt;
    if (cfg_alg == ALG_XS) begin
      adv_nxt    = wrk;
      adv_nxt[0] = xs_nxt;
    end
    raw = (cfg_alg == ALG_XS) ? wrk[0] : (wrk[4] + wrk[5]);
  end

  assign cmd_ready = (st == S_IDLE);
  assign acc       = cmd_valid && cmd_ready;
  assign cmd_good  = acc && !bad_algo && !bad_param;
  assign set_ok    = cmd_good && (cmd_op == OP_SET);
  assign out_valid = (st == S_EMIT);
  assign wb        = out_valid && out_ready;
  assign out_lane  = lane;
  assign out_last  = ((CW'(lane) + CW'(1)) == cfg_cnt);
  assign out_data  = (cfg_post == PP_UNIT) ? (UNIT_EXP | {9'd0, raw[31:9]}) : raw;

  // lane state storage: seeded by set-state, updated on output handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) mem[i] <= '0;
    end else if (set_ok) begin
      if (cmd_algo == ALG_XS)
        mem[cmd_lane][0] <= (seed_s[0] == '0) ? 32'd1 : seed_s[0];
      else
        mem[cmd_lane] <= seed_s;
    end else if (wb) begin
      mem[lane] <= wrk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wrk       <= '0;
      cnt       <= '0;
      lane      <= '0;
      cfg_ok    <= 1'b0;
      cfg_alg   <= ALG_XS;
      cfg_post  <= PP_RAW;
      cfg_steps <= '0;
      cfg_cnt   <= '0;
      err_algo  <= 1'b0;
      err_param <= 1'b0;
      rd_valid  <= 1'b0;
      rd_words  <= '0;
    end else begin
      err_algo  <= acc && bad_algo;
      err_param <= acc && bad_param;
      rd_valid  <= cmd_good && (cmd_op == OP_GET);
      if (cmd_good && (cmd_op == OP_GET)) begin
        if (cmd_algo == ALG_XS) rd_words <= {{(SWB-32){1'b0}}, mem[cmd_lane][0]};
        else                    rd_words <= mem[cmd_lane];
      end
      if (cmd_good && (cmd_op == OP_CFG)) begin
        cfg_ok    <= 1'b1;
        cfg_alg   <= cmd_algo;
        cfg_post  <= cmd_post;
        cfg_steps <= cmd_steps;
        cfg_cnt   <= cmd_count;
      end
      case (st)
        S_IDLE: if (cmd_good && (cmd_op == OP_GEN)) begin
          lane <= '0;
          st   <= S_LOAD;
        end
        S_LOAD: begin
          wrk <= mem[lane];
          cnt <= cfg_steps;
          st  <= S_ADV;
        end
        S_ADV: begin
          wrk <= adv_nxt;
          cnt <= cnt - STEPW'(1);
          if (cnt == STEPW'(1)) st <= S_EMIT;
        end
        default: if (wb) begin
          if (out_last) st <= S_IDLE;
          else begin
            lane <= lane + LW'(1);
            st   <= S_LOAD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rng_lanes_chk.sv
module rng_lanes_chk #(
  parameter int LANES = 128,
  localparam int LW = $clog2(LANES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data,
  input logic [LW-1:0] out_lane,
  input logic          out_last,
  input logic          err_algo,
  input logic          err_param,
  input logic          rd_valid
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_lane) && $stable(out_last));
  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);
  // R10
  last_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);
  // R1
  rej_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_algo |-> !rd_valid);
  // R1
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_algo && err_param));
  // R10
  err_nogen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_param && cmd_ready |=> !out_valid);
endmodule

bind rng_lanes rng_lanes_chk #(.LANES(LANES)) u_lanes_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_lane(out_lane),
  .out_last(out_last), .err_algo(err_algo), .err_param(err_param),
  .rd_valid(rd_valid)
);

// File: tb/rng_lanes_tb.sv
module rng_lanes_tb;
  localparam int L = 16;
  localparam int LW = 4;
  localparam int CW = 5;
  localparam int SWB = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0, cmd_algo = '0, cmd_src = '0, cmd_post = '0;
  logic [LW-1:0] cmd_lane = '0;
  logic [7:0] cmd_steps = '0;
  logic [CW-1:0] cmd_count = '0;
  logic [SWB-1:0] cmd_seed = '0;
  logic err_algo, err_param, rd_valid, out_valid, out_last;
  logic out_ready = 1'b0;
  logic [SWB-1:0] rd_words;
  logic [31:0] out_data;
  logic [LW-1:0] out_lane;

  rng_lanes #(.LANES(L), .STEPW(8)) u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] m [L][6];
  logic [1:0] c_alg, c_post;
  int c_steps;
  logic g_ea, g_ep, g_rv;
  logic [SWB-1:0] g_rw;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [SWB-1:0] act, input logic [SWB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] f_xs(input logic [31:0] s);
    logic [31:0] a, b;
    a = s ^ (s << 13);
    b = a ^ (a >> 17);
    return b ^ (b << 5);
  endfunction

  task automatic model_adv(input int ln);
    logic [31:0] t;
    if (c_alg == 2'd0) m[ln][0] = f_xs(m[ln][0]);
    else begin
      t = m[ln][0] ^ (m[ln][0] >> 2);
      m[ln][0] = m[ln][1]; m[ln][1] = m[ln][2]; m[ln][2] = m[ln][3]; m[ln][3] = m[ln][4];
      m[ln][4] = (m[ln][4] ^ (m[ln][4] << 4)) ^ (t ^ (t << 1));
      m[ln][5] = m[ln][5] + 32'd362437;
    end
  endtask

  function automatic logic [SWB-1:0] model_get(input int ln, input logic [1:0] a);
    if (a == 2'd0) return {160'd0, m[ln][0]};
    return {m[ln][5], m[ln][4], m[ln][3], m[ln][2], m[ln][1], m[ln][0]};
  endfunction

  function automatic logic [SWB-1:0] rnd_seed();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic do_cmd(input logic [1:0] op, input int lane, input logic [1:0] algo,
                        input logic [1:0] src, input int steps, input logic [1:0] post,
                        input int count, input logic [SWB-1:0] seed);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_lane = LW'(lane); cmd_algo = algo; cmd_src = src;
    cmd_steps = 8'(steps); cmd_post = post; cmd_count = CW'(count); cmd_seed = seed;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    g_ea = err_algo; g_ep = err_param; g_rv = rd_valid; g_rw = rd_words;
  endtask

  task automatic cfg_cmd(input logic [1:0] a, input logic [1:0] s, input int st,
                         input logic [1:0] p, input int n, input bit xa, input bit xp,
                         input string tag);
    do_cmd(2'd0, 0, a, s, st, p, n, '0);
    check(g_ea == xa && g_ep == xp, tag, "configure flags", {g_ea, g_ep}, {xa, xp});
    if (!xa && !xp) begin c_alg = a; c_steps = st; c_post = p; end
  endtask

  task automatic set_cmd(input int ln, input logic [1:0] a, input logic [1:0] s,
                         input logic [SWB-1:0] sd, input bit xa, input bit xp, input string tag);
    do_cmd(2'd1, ln, a, s, 1, 2'd0, 1, sd);
    check(g_ea == xa && g_ep == xp, tag, "set-state flags", {g_ea, g_ep}, {xa, xp});
    if (!xa && !xp) begin
      if (a == 2'd0) m[ln][0] = (sd[31:0] == '0) ? 32'd1 : sd[31:0];
      else for (int k = 0; k < 6; k++) m[ln][k] = sd[32*k +: 32];
    end
  endtask

  task automatic get_cmd(input int ln, input logic [1:0] a, input logic [1:0] s, input string tag);
    do_cmd(2'd2, ln, a, s, 1, 2'd0, 1, '0);
    check(g_rv && !g_ea && !g_ep, tag, "get-state valid", {g_rv, g_ea, g_ep}, 3'b100);
    check(g_rw == model_get(ln, a), tag, "get-state words", g_rw, model_get(ln, a));
  endtask

  task automatic gen_cmd(input int n, input string tag);
    logic [31:0] raw, exp;
    bit r;
    do_cmd(2'd3, 0, 2'd0, 2'd0, 1, 2'd0, 1, '0);
    check(!g_ea && !g_ep, "R10", "generate accepted", {g_ea, g_ep}, 2'b00);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < c_steps; k++) model_adv(i);
      raw = (c_alg == 2'd0) ? m[i][0] : (m[i][4] + m[i][5]);
      exp = (c_post == 2'd1) ? (32'h3F80_0000 | {9'd0, raw[31:9]}) : raw;
      forever begin
        r = ($urandom % 4) != 0;
        out_ready = r;
        if (out_valid && r) break;
        @(negedge clk);
      end
      check(out_data == exp, tag, "output word", out_data, exp);
      check(out_lane == LW'(i) && out_last == (i == n - 1), "R10", "lane order and last",
            {out_lane, out_last}, {LW'(i), i == n - 1});
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(cmd_ready && !out_valid, "R11", "ready after run", {cmd_ready, out_valid}, 2'b10);
  endtask

  initial begin
    logic [SWB-1:0] sd;
    void'($urandom(32'd4242));
    for (int i = 0; i < L; i++) for (int k = 0; k < 6; k++) m[i][k] = '0;
    c_alg = 2'd0; c_post = 2'd0; c_steps = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(cmd_ready && !out_valid && !err_algo && !err_param && !rd_valid, "R12", "reset outputs",
          {cmd_ready, out_valid, err_algo, err_param, rd_valid}, 5'b10000);
    // R10 generate without configuration
    do_cmd(2'd3, 0, 2'd0, 2'd0, 1, 2'd0, 1, '0);
    check(g_ep && !g_ea, "R10", "generate unconfigured", {g_ea, g_ep}, 2'b01);
    repeat (4) @(negedge clk);
    check(!out_valid && cmd_ready, "R10", "no output unconfigured", {out_valid, cmd_ready}, 2'b01);
    get_cmd(3, 2'd3, 2'd1, "R12");
    // R1 unsupported algorithm codes
    cfg_cmd(2'd1, 2'd0, 1, 2'd0, 1, 1, 0, "R1");
    cfg_cmd(2'd2, 2'd0, 1, 2'd0, 1, 1, 0, "R1");
    set_cmd(2, 2'd1, 2'd0, rnd_seed(), 1, 0, "R1");
    set_cmd(2, 2'd2, 2'd1, rnd_seed(), 1, 0, "R1");
    get_cmd(2, 2'd3, 2'd1, "R1");
    do_cmd(2'd2, 2, 2'd2, 2'd1, 1, 2'd0, 1, '0);
    check(g_ea && !g_rv, "R1", "get with code 2", {g_ea, g_rv}, 2'b10);
    do_cmd(2'd3, 0, 2'd0, 2'd0, 1, 2'd0, 1, '0);
    check(g_ep, "R1", "rejected configure left none valid", g_ep, 1'b1);
    // R2 source pairing
    cfg_cmd(2'd0, 2'd1, 1, 2'd0, 1, 0, 1, "R2");
    cfg_cmd(2'd3, 2'd0, 1, 2'd0, 1, 0, 1, "R2");
    set_cmd(4, 2'd3, 2'd3, rnd_seed(), 0, 1, "R2");
    get_cmd(4, 2'd3, 2'd1, "R2");
    do_cmd(2'd2, 4, 2'd0, 2'd1, 1, 2'd0, 1, '0);
    check(g_ep && !g_rv, "R2", "get mismatched source", {g_ep, g_rv}, 2'b10);
    cfg_cmd(2'd0, 2'd3, 1, 2'd0, 1, 0, 0, "R2");
    // R3 step count rules
    cfg_cmd(2'd0, 2'd0, 0, 2'd0, 1, 0, 1, "R3");
    cfg_cmd(2'd3, 2'd1, 2, 2'd0, 1, 0, 1, "R3");
    cfg_cmd(2'd0, 2'd0, 255, 2'd0, 1, 0, 0, "R3");
    // R4 post-process and lane count
    cfg_cmd(2'd0, 2'd0, 1, 2'd2, 1, 0, 1, "R4");
    cfg_cmd(2'd0, 2'd0, 1, 2'd3, 1, 0, 1, "R4");
    cfg_cmd(2'd0, 2'd0, 1, 2'd0, 0, 0, 1, "R4");
    cfg_cmd(2'd0, 2'd0, 1, 2'd0, L + 1, 0, 1, "R4");
    cfg_cmd(2'd0, 2'd0, 1, 2'd0, L, 0, 0, "R4");
    // R5 shift-register seeding
    sd = '0; sd[31:0] = 32'h1234; sd[95:64] = 32'h1;
    set_cmd(1, 2'd0, 2'd0, sd, 0, 1, "R5");
    get_cmd(1, 2'd0, 2'd0, "R5");
    set_cmd(1, 2'd0, 2'd3, '0, 0, 0, "R5");
    get_cmd(1, 2'd0, 2'd0, "R5");
    set_cmd(1, 2'd3, 2'd1, rnd_seed(), 0, 0, "R5");
    sd = '0; sd[31:0] = 32'd5;
    set_cmd(1, 2'd0, 2'd0, sd, 0, 0, "R5");
    get_cmd(1, 2'd3, 2'd1, "R6");
    // R7 directed xorshift run, 3 steps, 4 lanes
    for (int i = 0; i < 4; i++) begin
      sd = '0; sd[31:0] = $urandom;
      set_cmd(i, 2'd0, 2'd0, sd, 0, 0, "R5");
    end
    set_cmd(4, 2'd3, 2'd1, rnd_seed(), 0, 0, "R5");
    cfg_cmd(2'd0, 2'd0, 3, 2'd0, 4, 0, 0, "R7");
    gen_cmd(4, "R7");
    get_cmd(4, 2'd3, 2'd1, "R10");
    get_cmd(0, 2'd0, 2'd0, "R7");
    // R8 xorwow over every lane, then R9 float pattern
    for (int i = 0; i < L; i++) set_cmd(i, 2'd3, 2'd1, rnd_seed(), 0, 0, "R5");
    cfg_cmd(2'd3, 2'd1, 1, 2'd0, L, 0, 0, "R8");
    gen_cmd(L, "R8");
    get_cmd(L - 1, 2'd3, 2'd1, "R8");
    cfg_cmd(2'd3, 2'd1, 1, 2'd1, 5, 0, 0, "R9");
    gen_cmd(5, "R9");
    cfg_cmd(2'd0, 2'd0, 2, 2'd1, 3, 0, 0, "R9");
    gen_cmd(3, "R9");
    // random mix
    for (int it = 0; it < 8; it++) begin
      logic [1:0] a;
      int n, ln;
      a = ($urandom % 2) ? 2'd3 : 2'd0;
      n = 1 + ($urandom % L);
      for (int j = 0; j < 3; j++) begin
        ln = $urandom % L;
        sd = rnd_seed();
        if (a == 2'd0) sd[191:32] = '0;
        set_cmd(ln, a, (a == 2'd0) ? 2'd0 : 2'd1, sd, 0, 0, "R5");
      end
      cfg_cmd(a, (a == 2'd0) ? 2'd3 : 2'd1, (a == 2'd0) ? 1 + ($urandom % 5) : 1,
              2'($urandom % 2), n, 0, 0, "R3");
      gen_cmd(n, (a == 2'd0) ? "R7" : "R8");
      ln = $urandom % L;
      get_cmd(ln, 2'd3, 2'd1, "R10");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule